// File: doc/BRIEF.md
# Multithreaded Fetch Thread Selector

This block sits at the fetch stage of an in-order pipeline that interleaves several hardware threads. It holds one program counter per thread, reads one ready flag per thread, and on every clock edge picks at most one thread to issue. The chosen thread's identifier and its program counter leave the block together with a valid bit. The identifier then moves down a tag pipeline, one stage per cycle, so that each later stage of the pipeline knows which thread's register state the instruction in it belongs to.

Three scheduling policies are available:

- **Fixed rotation.** Each thread gets one slot in turn.
- **Slot table.** The thread sequence comes from a short table that software writes.
- **Priority.** A round-robin search picks among the threads that are ready.

In the two fixed policies, a slot whose owner is not ready becomes a bubble and is not handed to another thread. A redirect input lets the pipeline overwrite any thread's program counter, for example after a branch or an exception.

Top module: `thread_select_unit`

## Requirements
- R1: While reset is asserted and right after it, nothing issues and every tag stage is empty. Thread t's program counter starts at PC_BASE + t*PC_STRIDE. The policy starts as fixed rotation with its pointer at thread 0.
- R2: When `mode_i` is 0 (fixed rotation) or 3 (treated the same way), the k-th selection after the policy took effect goes to thread k mod N. If that thread is not ready, a bubble is issued in its place.
- R3: When `mode_i` is 1 (slot table), the selections walk the active table entries 0, 1, …, L-1 and then start again at 0, where L is the active length. Each selection issues the thread stored in the current entry, or a bubble if that thread is not ready or its id is not below N.
- R4: Table entry writes and length writes go to a staging copy. The staging copy becomes active on the edge that moves the slot pointer back to entry 0. Until then, the current pass through the table runs unchanged.
- R5: A length write whose value is 0 or greater than SLOTS is ignored, and the previous length stays in force.
- R6: When `mode_i` is 2 (priority), the block issues the first ready thread found by searching upward from the thread issued last and wrapping around. It issues a bubble only when no thread is ready. It never issues the same thread twice in a row while another thread is ready.
- R7: The edge at which `mode_i` first differs from the policy in force issues a bubble and adopts the new policy. The next selection starts with every rotation pointer at 0, and in priority mode the search starts at thread 0.
- R8: An issued thread's program counter appears on `issue_pc_o` with the issue. That program counter then advances by PC_INC.
- R9: A redirect replaces the named thread's program counter on the next edge. The redirect wins over the advance when the same thread issues on that edge.
- R10: Tag stage 0 is the issue output. Stage i shows the valid bit and thread id that stage 0 held i cycles earlier. Stage i's id sits at bits [i*TID_W +: TID_W] of `stage_tid_o`.
- R11: A thread is only ever issued if its ready flag was set at the edge that selected it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Policy: 0 fixed, 1 table, 2 priority, 3 same as fixed |
| ready_i | input | NUM_THREADS | Per-thread ready flags |
| tbl_wr_en_i | input | 1 | Write a staging table entry |
| tbl_wr_idx_i | input | IDX_W | Entry index for the write |
| tbl_wr_tid_i | input | TID_W | Thread id written into the entry |
| len_wr_en_i | input | 1 | Write the staging length |
| len_wr_val_i | input | LEN_W | Table length, from 1 to SLOTS |
| redir_en_i | input | 1 | Overwrite a thread's program counter |
| redir_tid_i | input | TID_W | Thread whose program counter is overwritten |
| redir_pc_i | input | PC_W | New program counter value |
| issue_valid_o | output | 1 | An instruction issues this cycle |
| issue_tid_o | output | TID_W | Issuing thread |
| issue_pc_o | output | PC_W | Program counter of the issuing thread |
| stage_valid_o | output | STAGES | Valid bit per tag stage |
| stage_tid_o | output | STAGES*TID_W | Thread id per tag stage |

## Verification
The assertions check on every cycle that:

- each tag stage copies the stage before it;
- an issued thread was ready when it was chosen;
- a policy change produces exactly one bubble;
- fixed rotation advances by one thread per selection;
- priority mode never repeats a thread while another thread is waiting.

Other behaviour shows only in the bench's sweeps over every ready pattern in each policy: the exact slot order taken from the table, the deferral of table and length writes to the wrap, the rejection of bad lengths, the program counter values, and a redirect colliding with an issue.

// File: rtl/tsel_pkg.sv
package tsel_pkg;
   typedef enum logic [1:0] {
      SCHED_FIXED = 2'd0,
      SCHED_TABLE = 2'd1,
      SCHED_PRIO  = 2'd2,
      SCHED_ALT   = 2'd3
   } sched_mode_e;
endpackage

// File: rtl/tsel_prio_pick.sv
// Round-robin search: first requester strictly after 'last', wrapping.
module tsel_prio_pick #(
   parameter int NUM_THREADS = 4,
   parameter int TID_W       = 2
) (
   input  logic [NUM_THREADS-1:0] req,
   input  logic [TID_W-1:0]       last,
   output logic                   hit,
   output logic [TID_W-1:0]       pick
);
   always_comb begin
      int unsigned cand;
      hit  = 1'b0;
      pick = '0;
      for (int k = 1; k <= NUM_THREADS; k++) begin
         cand = (int'(last) + k) % NUM_THREADS;
         if (!hit && req[cand]) begin
            hit  = 1'b1;
            pick = cand[TID_W-1:0];
         end
      end
   end
endmodule

// File: rtl/tsel_slot_table.sv
// Staging and active slot tables; staging becomes active when the pointer returns to 0.
module tsel_slot_table #(
   parameter int NUM_THREADS = 4,
   parameter int SLOTS       = 8,
   parameter int TID_W       = 2,
   parameter int IDX_W       = 3,
   parameter int LEN_W       = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             advance,
   input  logic             restart,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TID_W-1:0] wr_tid,
   input  logic             len_wr_en,
   input  logic [LEN_W-1:0] len_wr_val,
   output logic [TID_W-1:0] cur_tid
);
   logic [IDX_W-1:0]       slot_q, slot_n;
   logic [LEN_W-1:0]       len_stage_q, len_act_q;
   logic [SLOTS*TID_W-1:0] act_flat;
   logic                   at_end, load_act, len_ok;

   assign at_end   = (LEN_W'(slot_q) == len_act_q - LEN_W'(1));
   assign len_ok   = (len_wr_val != '0) && (len_wr_val <= LEN_W'(SLOTS));

   always_comb begin
      if (restart)       slot_n = '0;
      else if (!advance) slot_n = slot_q;
      else if (at_end)   slot_n = '0;
      else               slot_n = slot_q + IDX_W'(1);
   end

   assign load_act = (slot_n == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q      <= '0;
         len_stage_q <= LEN_W'(SLOTS);
         len_act_q   <= LEN_W'(SLOTS);
      end else begin
         slot_q <= slot_n;
         if (load_act)           len_act_q   <= len_stage_q;
         if (len_wr_en && len_ok) len_stage_q <= len_wr_val;
      end
   end

   for (genvar e = 0; e < SLOTS; e++) begin : g_entry
      logic [TID_W-1:0] stage_r, act_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stage_r <= TID_W'(e % NUM_THREADS);
            act_r   <= TID_W'(e % NUM_THREADS);
         end else begin
            if (load_act)                            act_r   <= stage_r;
            if (wr_en && wr_idx == IDX_W'(e))        stage_r <= wr_tid;
         end
      end
      assign act_flat[e*TID_W +: TID_W] = act_r;
   end

   always_comb begin
      cur_tid = '0;
      for (int k = 0; k < SLOTS; k++)
         if (slot_q == IDX_W'(k)) cur_tid = act_flat[k*TID_W +: TID_W];
   end
endmodule

// File: rtl/tsel_pc_bank.sv
// One program counter per thread with advance and redirect.
module tsel_pc_bank #(
   parameter int NUM_THREADS = 4,
   parameter int TID_W       = 2,
   parameter int PC_W        = 16,
   parameter int PC_BASE     = 0,
   parameter int PC_STRIDE   = 4096,
   parameter int PC_INC      = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [TID_W-1:0] rd_tid,
   output logic [PC_W-1:0]  rd_pc,
   input  logic             inc_en,
   input  logic             redir_en,
   input  logic [TID_W-1:0] redir_tid,
   input  logic [PC_W-1:0]  redir_pc
);
   logic [NUM_THREADS*PC_W-1:0] pc_flat;

   for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
      logic [PC_W-1:0] pc_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            pc_r <= PC_W'(PC_BASE + t * PC_STRIDE);
         else if (redir_en && redir_tid == TID_W'(t))
            pc_r <= redir_pc;
         else if (inc_en && rd_tid == TID_W'(t))
            pc_r <= pc_r + PC_W'(PC_INC);
      end
      assign pc_flat[t*PC_W +: PC_W] = pc_r;
   end

   always_comb begin
      rd_pc = '0;
      for (int k = 0; k < NUM_THREADS; k++)
         if (rd_tid == TID_W'(k)) rd_pc = pc_flat[k*PC_W +: PC_W];
   end
endmodule

// File: rtl/tsel_stage_pipe.sv
// Thread tag shift register; stage 0 is the issue register.
module tsel_stage_pipe #(
   parameter int STAGES = 5,
   parameter int TID_W  = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic [TID_W-1:0]        in_tid,
   output logic [STAGES-1:0]       out_valid,
   output logic [STAGES*TID_W-1:0] out_tid
);
   for (genvar s = 0; s < STAGES; s++) begin : g_stg
      logic             v_src;
      logic [TID_W-1:0] t_src;
      if (s == 0) begin : g_head
         assign v_src = in_valid;
         assign t_src = in_tid;
      end else begin : g_body
         assign v_src = out_valid[s-1];
         assign t_src = out_tid[(s-1)*TID_W +: TID_W];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid[s]                 <= 1'b0;
            out_tid[s*TID_W +: TID_W]    <= '0;
         end else begin
            out_valid[s]                 <= v_src;
            out_tid[s*TID_W +: TID_W]    <= t_src;
         end
      end
   end
endmodule

// File: rtl/thread_select_unit.sv
module thread_select_unit
   import tsel_pkg::*;
#(
   parameter int NUM_THREADS = 4,
   parameter int SLOTS       = 8,
   parameter int STAGES      = 5,
   parameter int PC_W        = 16,
   parameter int PC_BASE     = 0,
   parameter int PC_STRIDE   = 4096,
   parameter int PC_INC      = 1,
   localparam int TID_W      = $clog2(NUM_THREADS),
   localparam int IDX_W      = $clog2(SLOTS),
   localparam int LEN_W      = $clog2(SLOTS + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [1:0]              mode_i,
   input  logic [NUM_THREADS-1:0]  ready_i,
   input  logic                    tbl_wr_en_i,
   input  logic [IDX_W-1:0]        tbl_wr_idx_i,
   input  logic [TID_W-1:0]        tbl_wr_tid_i,
   input  logic                    len_wr_en_i,
   input  logic [LEN_W-1:0]        len_wr_val_i,
   input  logic                    redir_en_i,
   input  logic [TID_W-1:0]        redir_tid_i,
   input  logic [PC_W-1:0]         redir_pc_i,
   output logic                    issue_valid_o,
   output logic [TID_W-1:0]        issue_tid_o,
   output logic [PC_W-1:0]         issue_pc_o,
   output logic [STAGES-1:0]       stage_valid_o,
   output logic [STAGES*TID_W-1:0] stage_tid_o
);
   localparam int TID_SPAN = 1 << TID_W;

   if (NUM_THREADS < 2) begin : g_bad_threads
      $error("thread_select_unit: NUM_THREADS must be at least 2");
   end
   if (SLOTS < 2) begin : g_bad_slots
      $error("thread_select_unit: SLOTS must be at least 2");
   end
   if (STAGES < 2) begin : g_bad_stages
      $error("thread_select_unit: STAGES must be at least 2");
   end
   if (PC_W < 2) begin : g_bad_pcw
      $error("thread_select_unit: PC_W too small");
   end

   sched_mode_e          mode_q;
   logic                 mode_chg;
   logic [TID_W-1:0]     rr_q, last_q;
   logic [TID_W-1:0]     tbl_tid, prio_tid, sel_tid;
   logic                 prio_hit, sel_valid;
   logic [TID_SPAN-1:0]  rdy_ext;
   logic [PC_W-1:0]      sel_pc;

   assign mode_chg = (mode_i != mode_q);
   assign rdy_ext  = TID_SPAN'(ready_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= SCHED_FIXED;
         rr_q   <= '0;
         last_q <= TID_W'(NUM_THREADS - 1);
      end else begin
         mode_q <= sched_mode_e'(mode_i);
         if (mode_chg || rr_q == TID_W'(NUM_THREADS - 1)) rr_q <= '0;
         else                                             rr_q <= rr_q + TID_W'(1);
         if (mode_chg)                                    last_q <= TID_W'(NUM_THREADS - 1);
         else if (sel_valid && mode_q == SCHED_PRIO)      last_q <= sel_tid;
      end
   end

   tsel_slot_table #(
      .NUM_THREADS(NUM_THREADS), .SLOTS(SLOTS), .TID_W(TID_W),
      .IDX_W(IDX_W), .LEN_W(LEN_W)
   ) u_table (
      .clk        (clk),
      .rst_n      (rst_n),
      .advance    (mode_q == SCHED_TABLE),
      .restart    (mode_chg || mode_q != SCHED_TABLE),
      .wr_en      (tbl_wr_en_i),
      .wr_idx     (tbl_wr_idx_i),
      .wr_tid     (tbl_wr_tid_i),
      .len_wr_en  (len_wr_en_i),
      .len_wr_val (len_wr_val_i),
      .cur_tid    (tbl_tid)
   );

   tsel_prio_pick #(.NUM_THREADS(NUM_THREADS), .TID_W(TID_W)) u_pick (
      .req  (ready_i),
      .last (last_q),
      .hit  (prio_hit),
      .pick (prio_tid)
   );

   always_comb begin
      sel_tid   = rr_q;
      sel_valid = 1'b0;
      unique case (mode_q)
         SCHED_TABLE: begin
            sel_tid   = tbl_tid;
            sel_valid = (int'(tbl_tid) < NUM_THREADS) && rdy_ext[tbl_tid];
         end
         SCHED_PRIO: begin
            sel_tid   = prio_tid;
            sel_valid = prio_hit;
         end
         default: begin
            sel_tid   = rr_q;
            sel_valid = rdy_ext[rr_q];
         end
      endcase
      if (mode_chg) sel_valid = 1'b0;
   end

   tsel_pc_bank #(
      .NUM_THREADS(NUM_THREADS), .TID_W(TID_W), .PC_W(PC_W),
      .PC_BASE(PC_BASE), .PC_STRIDE(PC_STRIDE), .PC_INC(PC_INC)
   ) u_pcs (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_tid    (sel_tid),
      .rd_pc     (sel_pc),
      .inc_en    (sel_valid),
      .redir_en  (redir_en_i && int'(redir_tid_i) < NUM_THREADS),
      .redir_tid (redir_tid_i),
      .redir_pc  (redir_pc_i)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         issue_pc_o <= '0;
      else if (sel_valid) issue_pc_o <= sel_pc;
   end

   tsel_stage_pipe #(.STAGES(STAGES), .TID_W(TID_W)) u_tags (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (sel_valid),
      .in_tid    (sel_tid),
      .out_valid (stage_valid_o),
      .out_tid   (stage_tid_o)
   );

   assign issue_valid_o = stage_valid_o[0];
   assign issue_tid_o   = stage_tid_o[TID_W-1:0];
endmodule

// File: rtl/thread_select_unit_chk.sv
module thread_select_unit_chk #(
   parameter int NUM_THREADS = 4,
   parameter int TID_W       = 2,
   parameter int STAGES      = 5
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [1:0]              mode_i,
   input logic [1:0]              mode_q,
   input logic [NUM_THREADS-1:0]  ready_i,
   input logic                    issue_valid_o,
   input logic [TID_W-1:0]        issue_tid_o,
   input logic [STAGES-1:0]       stage_valid_o,
   input logic [STAGES*TID_W-1:0] stage_tid_o
);
   logic [TID_W-1:0] tid_next;
   assign tid_next = TID_W'((int'(issue_tid_o) + 1) % NUM_THREADS);

   assert_switch_bubble_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i != mode_q) |=> !issue_valid_o);

   assert_issue_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid_o |-> ((($past(ready_i) >> issue_tid_o) & 1) != 0));

   assert_fixed_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == 2'd0 && mode_i == mode_q && issue_valid_o)
      |=> (!issue_valid_o || issue_tid_o == $past(tid_next)));

   assert_prio_no_repeat_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == 2'd2 && mode_i == mode_q && issue_valid_o &&
       ((ready_i & ~(NUM_THREADS'(1) << issue_tid_o)) != '0))
      |=> (issue_valid_o && issue_tid_o != $past(issue_tid_o)));

   for (genvar s = 1; s < STAGES; s++) begin : g_shift
      assert_tag_shift_R10: assert property (@(posedge clk) disable iff (!rst_n)
         stage_valid_o[s] == $past(stage_valid_o[s-1]) &&
         stage_tid_o[s*TID_W +: TID_W] == $past(stage_tid_o[(s-1)*TID_W +: TID_W]));
   end
endmodule

bind thread_select_unit thread_select_unit_chk #(
   .NUM_THREADS(NUM_THREADS), .TID_W(TID_W), .STAGES(STAGES)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .mode_i        (mode_i),
   .mode_q        (mode_q),
   .ready_i       (ready_i),
   .issue_valid_o (issue_valid_o),
   .issue_tid_o   (issue_tid_o),
   .stage_valid_o (stage_valid_o),
   .stage_tid_o   (stage_tid_o)
);

// File: tb/thread_select_unit_tb_top.sv
module thread_select_unit_tb_top;
   localparam int N = 4, SLOTS = 8, STAGES = 5, PC_W = 16;
   localparam int TID_W = 2, IDX_W = 3, LEN_W = 4;
   localparam int STRIDE = 4096, INC = 1;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [1:0] mode_i = 2'd0;
   logic [N-1:0] ready_i = '0;
   logic tbl_wr_en_i = 0, len_wr_en_i = 0, redir_en_i = 0;
   logic [IDX_W-1:0] tbl_wr_idx_i = '0;
   logic [TID_W-1:0] tbl_wr_tid_i = '0, redir_tid_i = '0;
   logic [LEN_W-1:0] len_wr_val_i = '0;
   logic [PC_W-1:0] redir_pc_i = '0;
   logic issue_valid_o;
   logic [TID_W-1:0] issue_tid_o;
   logic [PC_W-1:0] issue_pc_o;
   logic [STAGES-1:0] stage_valid_o;
   logic [STAGES*TID_W-1:0] stage_tid_o;

   always #10 clk = ~clk;

   thread_select_unit #(.NUM_THREADS(N), .SLOTS(SLOTS), .STAGES(STAGES), .PC_W(PC_W),
      .PC_BASE(0), .PC_STRIDE(STRIDE), .PC_INC(INC)) dut_i (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .ready_i(ready_i),
      .tbl_wr_en_i(tbl_wr_en_i), .tbl_wr_idx_i(tbl_wr_idx_i), .tbl_wr_tid_i(tbl_wr_tid_i),
      .len_wr_en_i(len_wr_en_i), .len_wr_val_i(len_wr_val_i),
      .redir_en_i(redir_en_i), .redir_tid_i(redir_tid_i), .redir_pc_i(redir_pc_i),
      .issue_valid_o(issue_valid_o), .issue_tid_o(issue_tid_o), .issue_pc_o(issue_pc_o),
      .stage_valid_o(stage_valid_o), .stage_tid_o(stage_tid_o));

   int checks = 0, errors = 0;
   bit done = 0;
   int model_mode = 0, rr = 0, slot = 0, last = N - 1;
   int pcm[N];
   int act_tab[SLOTS], stg_tab[SLOTS];
   int act_len = SLOTS, stg_len = SLOTS;
   int hv[STAGES], ht[STAGES];

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   // One selection: drive inputs (already set by caller), model it, check after the edge.
   task automatic step(input logic [N-1:0] rdy, input string tag);
      int ev, et, ep, nslot;
      ready_i = rdy;
      ev = 0; et = 0; ep = 0;
      nslot = 0;
      if (int'(mode_i) != model_mode) begin
         model_mode = int'(mode_i);
         rr = 0; last = N - 1; nslot = 0;
      end else if (model_mode == 1) begin
         et = act_tab[slot];
         ev = (et < N) ? int'(rdy[et]) : 0;
         nslot = (slot == act_len - 1) ? 0 : slot + 1;
      end else if (model_mode == 2) begin
         for (int k = 1; k <= N; k++) begin
            int c;
            c = (last + k) % N;
            if (ev == 0 && rdy[c]) begin ev = 1; et = c; end
         end
         if (ev != 0) last = et;
      end else begin
         et = rr; ev = int'(rdy[rr]);
         rr = (rr + 1) % N;
      end
      slot = nslot;
      if (nslot == 0) begin
         for (int e = 0; e < SLOTS; e++) act_tab[e] = stg_tab[e];
         act_len = stg_len;
      end
      if (tbl_wr_en_i) stg_tab[tbl_wr_idx_i] = int'(tbl_wr_tid_i);
      if (len_wr_en_i && len_wr_val_i != 0 && int'(len_wr_val_i) <= SLOTS)
         stg_len = int'(len_wr_val_i);
      if (ev != 0) begin
         ep = pcm[et];
         pcm[et] = (pcm[et] + INC) & 16'hFFFF;
      end
      if (redir_en_i) pcm[redir_tid_i] = int'(redir_pc_i);
      for (int s = STAGES - 1; s > 0; s--) begin hv[s] = hv[s-1]; ht[s] = ht[s-1]; end
      hv[0] = ev; ht[0] = et;
      @(negedge clk);
      tbl_wr_en_i = 0; len_wr_en_i = 0; redir_en_i = 0;
      chk({tag, " valid"}, int'(issue_valid_o), ev);
      if (ev != 0) begin
         chk({tag, " tid"}, int'(issue_tid_o), et);
         chk("R8 pc", int'(issue_pc_o), ep);
      end
      for (int s = 1; s < STAGES; s++) begin
         chk("R10 stage valid", int'(stage_valid_o[s]), hv[s]);
         if (hv[s] != 0) chk("R10 stage tid", int'(stage_tid_o[s*TID_W +: TID_W]), ht[s]);
      end
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog R1 actual hung expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int t = 0; t < N; t++) pcm[t] = t * STRIDE;
      for (int e = 0; e < SLOTS; e++) begin act_tab[e] = e % N; stg_tab[e] = e % N; end
      for (int s = 0; s < STAGES; s++) begin hv[s] = 0; ht[s] = 0; end
      ready_i = '1;
      repeat (3) @(negedge clk);
      chk("R1 reset valid", int'(issue_valid_o), 0);
      chk("R1 reset stages", int'(stage_valid_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      // the edge just passed already selected with all ready
      hv[0] = 1; ht[0] = 0; rr = 1; pcm[0] = INC;
      chk("R1 first issue", int'(issue_tid_o), 0);
      chk("R1 first pc", int'(issue_pc_o), 0);
      for (int j = 0; j < 3; j++) step('1, "R1");
      // R2: fixed rotation over every ready pattern
      for (int p = 0; p < 16; p++)
         for (int j = 0; j < 4; j++) step(4'(p), "R2");
      // program the staging table while in fixed mode
      for (int e = 0; e < SLOTS; e++) begin
         int v[8] = '{0, 0, 1, 2, 3, 3, 1, 0};
         tbl_wr_en_i = 1; tbl_wr_idx_i = 3'(e); tbl_wr_tid_i = 2'(v[e]);
         step('1, "R2");
      end
      // R7 then R3: table mode over every ready pattern
      mode_i = 2'd1;
      step('1, "R7");
      for (int p = 0; p < 16; p++)
         for (int j = 0; j < 8; j++) step(4'(p), "R3");
      // R4: mid-rotation writes deferred to the wrap
      while (slot != 2) step('1, "R4");
      tbl_wr_en_i = 1; tbl_wr_idx_i = 3'd5; tbl_wr_tid_i = 2'd2;
      len_wr_en_i = 1; len_wr_val_i = 4'd6;
      step('1, "R4");
      for (int j = 0; j < 18; j++) step('1, "R4");
      // R5: illegal lengths ignored
      len_wr_en_i = 1; len_wr_val_i = 4'd0;
      step('1, "R5");
      len_wr_en_i = 1; len_wr_val_i = 4'd9;
      step('1, "R5");
      for (int j = 0; j < 16; j++) step(4'b1011, "R5");
      // R7 then R6: priority mode
      mode_i = 2'd2;
      step('1, "R7");
      step('1, "R7");
      for (int p = 0; p < 16; p++)
         for (int j = 0; j < 3; j++) step(4'(p), "R6");
      // R9: redirects, including one colliding with the same thread's issue
      mode_i = 2'd0;
      step('1, "R7");
      redir_en_i = 1; redir_tid_i = 2'd2; redir_pc_i = 16'h0123;
      step('1, "R9");
      redir_en_i = 1; redir_tid_i = 2'd1; redir_pc_i = 16'h4000;
      step('1, "R9");
      for (int j = 0; j < 8; j++) step('1, "R9");
      // mode 3 behaves as fixed rotation
      mode_i = 2'd3;
      step('1, "R7");
      for (int j = 0; j < 8; j++) step(4'b0110, "R2");
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule